// File: doc/BRIEF.md
# Five-Stage Operand Bypass and Interlock Controller

This controller decides, for an instruction sitting in decode, where each of its three source operands should come from when it moves into execute. The operand can come from the register file or be taken early from one of three in-flight results. A result sitting in execute will be held in the execute/buffer register next cycle. A result in the buffer stage will be held in the buffer/writeback register. A result in writeback is being written this cycle. When several in-flight producers write the same register, the youngest one wins.

Two situations cannot be covered by bypassing alone. A single load needs one cycle before its data exists, so it costs one stall. A load-multiple writes its highest-numbered register latest, so that register costs two stalls. In both cases the controller holds the PC and the fetch/decode register and sends a bubble into execute. To do this the controller keeps a small record of a load-multiple's highest destination as it moves down the pipe. The surrounding pipeline holds decode steady during a stall and places a bubble in execute.

Top module: `hz_fwd_interlock`

## Requirements
- R1: Reset is asynchronous and active low. After reset, with no producers valid, every select is 0 and no stall is raised, even if a load-multiple was in flight when reset was applied.
- R2: `fwd_sel` for source i sits in bits [2i+1:2i]. The codes are 0 = register file, 1 = execute-stage producer, 2 = buffer-stage producer and 3 = writeback-stage producer. A non-load producer in execute whose destination equals a used source gives code 1 with no stall.
- R3: A producer in the buffer stage that matches a used source gives code 2. So ADD r1, then SUB reading r1, then AND reading r1 runs with codes 1 and then 2 and no stall.
- R4: A producer in writeback that matches a used source gives code 3.
- R5: When more than one stage matches, the youngest wins: execute over buffer over writeback.
- R6: A producer whose write enable is low never matches. A source whose use bit is low always gets code 0 and never stalls.
- R7: Register index 15 (the PC) is never forwarded and never causes a stall, whether it appears as a source or as a destination.
- R8: A load in execute whose destination is a used source raises `pc_hold`, `ifid_hold` and `ex_bubble` together for one cycle. On the next cycle the load is in the buffer stage and the source gets code 2.
- R9: A sequence of N instructions with no load hazard takes N+3 cycles from the first entering decode to the last leaving writeback. Each load-use interlock adds exactly one cycle, so six instructions take 9 or 10 cycles.
- R10: A load-multiple in execute marks its destinations in `ex_ldm_list`, where bit n stands for register n. A used source found in that list causes one stall. If the source is not the highest listed register, it then reads the register file (code 0) with no further stall.
- R11: A source that equals the highest register of a preceding load-multiple stalls for two cycles. It then gets code 3 while the load-multiple is in writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_src_idx | input | NSRC*RW | Source register numbers of the decode instruction, source i at [RW*i +: RW] |
| id_src_use | input | NSRC | Per-source use bit |
| ex_dst | input | RW | Destination of the execute-stage instruction |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a single load |
| ex_is_ldm | input | 1 | Execute-stage instruction is a load-multiple |
| ex_ldm_list | input | NREGS | Register list of the load-multiple, one bit per register |
| mem_dst | input | RW | Destination of the buffer-stage instruction |
| mem_wen | input | 1 | Buffer-stage instruction writes a register (low for load-multiple) |
| wb_dst | input | RW | Destination of the writeback-stage instruction |
| wb_wen | input | 1 | Writeback-stage instruction writes a register (low for load-multiple) |
| fwd_sel | output | NSRC*2 | Per-source operand select code |
| pc_hold | output | 1 | Hold the program counter |
| ifid_hold | output | 1 | Hold the fetch/decode register |
| ex_bubble | output | 1 | Inject a non-writing bubble into execute |

## Verification
The bench sweeps every source and destination pairing against each producer stage on its own. It then sweeps every combination of stage write enables with all stages naming the same register. This catches a reversed priority chain, a missing write-enable qualifier, and a PC comparison that is not excluded. Short instruction sequences run through a bench-side pipeline model that reacts to the stall outputs. These sequences check that a load-use hazard costs exactly one cycle and then bypasses from the buffer stage. They also check that a load-multiple's highest register costs exactly two cycles and then bypasses from writeback. A controller that cleared its load-multiple record too early would skip the second stall. One that kept the record too long, or did not clear it on reset, would stall where none is due.

// File: rtl/hz_pkg.sv
package hz_pkg;
   typedef enum logic [1:0] {
      FW_RF  = 2'd0,
      FW_EXM = 2'd1,
      FW_MWB = 2'd2,
      FW_WBK = 2'd3
   } fwd_src_e;
endpackage

// File: rtl/hz_ldm_track.sv
// Follows the highest destination of a load-multiple through buffer and writeback.
module hz_ldm_track #(
   parameter int NREGS = 16,
   parameter int RW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ex_is_ldm,
   input  logic [NREGS-1:0] ex_ldm_list,
   output logic             ex_hi_vld,
   output logic [RW-1:0]    ex_hi,
   output logic             mem_vld,
   output logic [RW-1:0]    mem_hi,
   output logic             wb_vld,
   output logic [RW-1:0]    wb_hi
);
   always_comb begin
      ex_hi = '0;
      for (int n = 0; n < NREGS; n++) begin
         if (ex_ldm_list[n]) ex_hi = RW'(n);
      end
   end

   assign ex_hi_vld = ex_is_ldm && (|ex_ldm_list);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_vld <= 1'b0;
         mem_hi  <= '0;
         wb_vld  <= 1'b0;
         wb_hi   <= '0;
      end else begin
         mem_vld <= ex_hi_vld;
         mem_hi  <= ex_hi;
         wb_vld  <= mem_vld;
         wb_hi   <= mem_hi;
      end
   end

   assert_wb_follows_mem_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_vld |=> (wb_vld && wb_hi == $past(mem_hi)));
endmodule

// File: rtl/hz_src_cmp.sv
// Per-source comparison: bypass choice and interlock request.
module hz_src_cmp import hz_pkg::*; #(
   parameter int NREGS  = 16,
   parameter int RW     = 4,
   parameter int PC_IDX = 15,
   parameter bit FWD_WB = 1'b1
) (
   input  logic [RW-1:0]    src,
   input  logic             use_i,
   input  logic [RW-1:0]    ex_dst,
   input  logic             ex_wen,
   input  logic             ex_load,
   input  logic             ex_ldm,
   input  logic [NREGS-1:0] ex_ldm_list,
   input  logic [RW-1:0]    mem_dst,
   input  logic             mem_wen,
   input  logic             mem_ldm_vld,
   input  logic [RW-1:0]    mem_ldm_hi,
   input  logic [RW-1:0]    wb_dst,
   input  logic             wb_wen,
   input  logic             wb_ldm_vld,
   input  logic [RW-1:0]    wb_ldm_hi,
   output logic [1:0]       sel,
   output logic             stall
);
   localparam logic [RW-1:0] PC_R = RW'(PC_IDX);

   logic live, hit_ex, hit_ldm, hit_mem, hit_mem_hi, hit_wb;

   assign live       = use_i && (src != PC_R);
   assign hit_ex     = live && ex_wen && !ex_ldm && (ex_dst == src);
   assign hit_ldm    = live && ex_ldm && ex_ldm_list[src];
   assign hit_mem    = live && mem_wen && (mem_dst == src);
   assign hit_mem_hi = live && mem_ldm_vld && (mem_ldm_hi == src);

   generate
      if (FWD_WB) begin : g_wb_path
         assign hit_wb = live && ((wb_wen && (wb_dst == src)) ||
                                  (wb_ldm_vld && (wb_ldm_hi == src)));
      end else begin : g_wb_none
         assign hit_wb = 1'b0;
      end
   endgenerate

   assign stall = (hit_ex && ex_load) || hit_ldm || hit_mem_hi;

   always_comb begin
      fwd_src_e s;
      if (hit_ex)       s = FW_EXM;
      else if (hit_mem) s = FW_MWB;
      else if (hit_wb)  s = FW_WBK;
      else              s = FW_RF;
      sel = s;
   end
endmodule

// File: rtl/hz_fwd_interlock.sv
module hz_fwd_interlock import hz_pkg::*; #(
   parameter int NREGS  = 16,
   parameter int RW     = 4,
   parameter int NSRC   = 3,
   parameter int PC_IDX = 15,
   parameter bit FWD_WB = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NSRC*RW-1:0]   id_src_idx,
   input  logic [NSRC-1:0]      id_src_use,
   input  logic [RW-1:0]        ex_dst,
   input  logic                 ex_wen,
   input  logic                 ex_is_load,
   input  logic                 ex_is_ldm,
   input  logic [NREGS-1:0]     ex_ldm_list,
   input  logic [RW-1:0]        mem_dst,
   input  logic                 mem_wen,
   input  logic [RW-1:0]        wb_dst,
   input  logic                 wb_wen,
   output logic [NSRC*2-1:0]    fwd_sel,
   output logic                 pc_hold,
   output logic                 ifid_hold,
   output logic                 ex_bubble
);
   localparam logic [RW-1:0] PC_R = RW'(PC_IDX);

   generate
      if (NSRC < 1 || NSRC > 8) begin : g_bad_nsrc
         $error("NSRC out of range");
      end
      if ((1 << RW) < NREGS) begin : g_bad_rw
         $error("RW too narrow for NREGS");
      end
      if (PC_IDX >= NREGS) begin : g_bad_pc
         $error("PC_IDX outside register file");
      end
   endgenerate

   logic            ex_hi_vld, mem_ldm_vld, wb_ldm_vld;
   logic [RW-1:0]   ex_hi, mem_ldm_hi, wb_ldm_hi;
   logic [NSRC-1:0] stall_v;

   hz_ldm_track #(.NREGS(NREGS), .RW(RW)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .ex_is_ldm  (ex_is_ldm),
      .ex_ldm_list(ex_ldm_list),
      .ex_hi_vld  (ex_hi_vld),
      .ex_hi      (ex_hi),
      .mem_vld    (mem_ldm_vld),
      .mem_hi     (mem_ldm_hi),
      .wb_vld     (wb_ldm_vld),
      .wb_hi      (wb_ldm_hi)
   );

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         logic [RW-1:0] s_idx;
         logic [1:0]    s_sel;
         assign s_idx = id_src_idx[i*RW +: RW];

         hz_src_cmp #(.NREGS(NREGS), .RW(RW), .PC_IDX(PC_IDX), .FWD_WB(FWD_WB)) u_cmp (
            .src        (s_idx),
            .use_i      (id_src_use[i]),
            .ex_dst     (ex_dst),
            .ex_wen     (ex_wen),
            .ex_load    (ex_is_load),
            .ex_ldm     (ex_is_ldm),
            .ex_ldm_list(ex_ldm_list),
            .mem_dst    (mem_dst),
            .mem_wen    (mem_wen),
            .mem_ldm_vld(mem_ldm_vld),
            .mem_ldm_hi (mem_ldm_hi),
            .wb_dst     (wb_dst),
            .wb_wen     (wb_wen),
            .wb_ldm_vld (wb_ldm_vld),
            .wb_ldm_hi  (wb_ldm_hi),
            .sel        (s_sel),
            .stall      (stall_v[i])
         );
         assign fwd_sel[i*2 +: 2] = s_sel;

         assert_pc_never_bypassed_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (id_src_use[i] && s_idx == PC_R) |-> (s_sel == FW_RF && !stall_v[i]));

         assert_sel_needs_wen_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ((s_sel == FW_EXM) |-> (ex_wen && !ex_is_ldm)) and
            ((s_sel == FW_MWB) |-> mem_wen) and
            ((s_sel == FW_WBK) |-> (wb_wen || wb_ldm_vld)));

         assert_load_use_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ex_is_load && ex_wen && !ex_is_ldm && id_src_use[i] &&
             s_idx == ex_dst && s_idx != PC_R) |-> (pc_hold && ifid_hold && ex_bubble));

         assert_ldm_hi_second_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (ex_hi_vld && id_src_use[i] && s_idx == ex_hi && s_idx != PC_R) |=>
            (!($stable(s_idx) && $stable(id_src_use[i])) || pc_hold));
      end
   endgenerate

   assign pc_hold   = |stall_v;
   assign ifid_hold = pc_hold;
   assign ex_bubble = pc_hold;

   assert_stall_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pc_hold |-> (ex_is_load || ex_is_ldm || mem_ldm_vld));
endmodule

// File: tb/hz_fwd_interlock_tb.sv
module hz_fwd_interlock_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NREGS = 16;
   localparam int RW    = 4;
   localparam int NSRC  = 3;

   typedef struct packed {
      logic          vld;
      int            tag;
      logic [3:0]    dst;
      logic          wen;
      logic          ld;
      logic          ldm;
      logic [15:0]   lst;
      logic [3:0]    s0, s1, s2;
      logic [2:0]    u;
   } rec_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NSRC*RW-1:0] id_src_idx;
   logic [NSRC-1:0]    id_src_use;
   logic [RW-1:0]      ex_dst, mem_dst, wb_dst;
   logic               ex_wen, ex_is_load, ex_is_ldm, mem_wen, wb_wen;
   logic [NREGS-1:0]   ex_ldm_list;
   logic [NSRC*2-1:0]  fwd_sel;
   logic               pc_hold, ifid_hold, ex_bubble;

   int checks = 0;
   int errors = 0;

   rec_t id_r, ex_r, mem_r, wb_r;
   rec_t prog [0:7];
   logic exp_stall;

   always #(CLK_PERIOD/2) clk = ~clk;

   hz_fwd_interlock u_dut (
      .clk(clk), .rst_n(rst_n), .id_src_idx(id_src_idx), .id_src_use(id_src_use),
      .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_is_load(ex_is_load), .ex_is_ldm(ex_is_ldm),
      .ex_ldm_list(ex_ldm_list), .mem_dst(mem_dst), .mem_wen(mem_wen),
      .wb_dst(wb_dst), .wb_wen(wb_wen), .fwd_sel(fwd_sel), .pc_hold(pc_hold),
      .ifid_hold(ifid_hold), .ex_bubble(ex_bubble)
   );

   function automatic rec_t mk(int tag, int dst, bit wen, bit ld, bit ldm, logic [15:0] lst,
                               int a, int b, int c, logic [2:0] u);
      rec_t r;
      r.vld = 1'b1; r.tag = tag; r.dst = 4'(dst); r.wen = wen; r.ld = ld; r.ldm = ldm;
      r.lst = lst; r.s0 = 4'(a); r.s1 = 4'(b); r.s2 = 4'(c); r.u = u;
      return r;
   endfunction

   function automatic rec_t bub();
      rec_t r;
      r = '0;
      return r;
   endfunction

   function automatic int top_bit(rec_t r);
      int h;
      h = -1;
      if (r.vld && r.ldm)
         for (int n = 0; n < 16; n++) if (r.lst[n]) h = n;
      return h;
   endfunction

   // expected {stall, select} for one source, from the requirements
   function automatic logic [2:0] ref_one(logic [3:0] s, logic u);
      logic st;
      logic [1:0] sl;
      st = 1'b0; sl = 2'd0;
      if (!u || s == 4'd15) return 3'b000;
      if (wb_r.vld && ((wb_r.wen && !wb_r.ldm && wb_r.dst == s) || top_bit(wb_r) == int'(s))) sl = 2'd3;
      if (mem_r.vld && mem_r.wen && !mem_r.ldm && mem_r.dst == s) sl = 2'd2;
      if (ex_r.vld && ex_r.wen && !ex_r.ldm && ex_r.dst == s) begin
         sl = 2'd1;
         if (ex_r.ld) st = 1'b1;
      end
      if (ex_r.vld && ex_r.ldm && ex_r.lst[s]) st = 1'b1;
      if (top_bit(mem_r) == int'(s)) st = 1'b1;
      return {st, sl};
   endfunction

   task automatic drive();
      id_src_idx = {id_r.s2, id_r.s1, id_r.s0};
      id_src_use = id_r.vld ? id_r.u : 3'b000;
      ex_dst = ex_r.dst;
      ex_wen = ex_r.vld && ex_r.wen && !ex_r.ldm;
      ex_is_load = ex_r.vld && ex_r.ld && !ex_r.ldm;
      ex_is_ldm = ex_r.vld && ex_r.ldm;
      ex_ldm_list = (ex_r.vld && ex_r.ldm) ? ex_r.lst : 16'h0;
      mem_dst = mem_r.dst;
      mem_wen = mem_r.vld && mem_r.wen && !mem_r.ldm;
      wb_dst = wb_r.dst;
      wb_wen = wb_r.vld && wb_r.wen && !wb_r.ldm;
   endtask

   task automatic check(string req);
      logic [2:0] e;
      logic [3:0] sv [NSRC];
      logic [1:0] got;
      sv[0] = id_r.s0; sv[1] = id_r.s1; sv[2] = id_r.s2;
      exp_stall = 1'b0;
      for (int i = 0; i < NSRC; i++) begin
         e = ref_one(sv[i], id_r.vld && id_r.u[i]);
         exp_stall = exp_stall | e[2];
         got = fwd_sel[i*2 +: 2];
         checks++;
         if (got !== e[1:0]) begin
            errors++;
            $display("FAIL %s sel[%0d] actual=%0d expected=%0d", req, i, got, e[1:0]);
         end
      end
      checks++;
      if (pc_hold !== exp_stall || ifid_hold !== exp_stall || ex_bubble !== exp_stall) begin
         errors++;
         $display("FAIL %s stall actual=%b%b%b expected=%b", req, pc_hold, ifid_hold, ex_bubble, exp_stall);
      end
   endtask

   task automatic step(string req);
      @(posedge clk); #1;
      drive();
      @(negedge clk);
      check(req);
   endtask

   task automatic run_seq(int n, int exp_stalls, string req);
      int cyc, scnt, pc;
      logic prev;
      id_r = prog[0]; ex_r = bub(); mem_r = bub(); wb_r = bub();
      pc = 1; cyc = 0; scnt = 0; prev = 1'b0;
      for (int c = 0; c < 60; c++) begin
         @(posedge clk); #1;
         if (c > 0) begin
            wb_r = mem_r; mem_r = ex_r;
            if (prev) ex_r = bub();
            else begin
               ex_r = id_r;
               if (pc < n) begin id_r = prog[pc]; pc++; end
               else id_r = bub();
            end
         end
         drive();
         @(negedge clk);
         check(req);
         prev = exp_stall;
         cyc++;
         if (exp_stall) scnt++;
         if (wb_r.vld && wb_r.tag == n-1) break;
      end
      checks++;
      if (scnt != exp_stalls) begin
         errors++;
         $display("FAIL %s stall cycles actual=%0d expected=%0d", req, scnt, exp_stalls);
      end
      checks++;
      if (cyc != n + 3 + exp_stalls) begin
         errors++;
         $display("FAIL R9 %s total cycles actual=%0d expected=%0d", req, cyc, n + 3 + exp_stalls);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      errors++;
      $display("FAIL all watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      id_r = bub(); ex_r = bub(); mem_r = bub(); wb_r = bub();
      drive();
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 in reset");
      rst_n = 1'b1;
      // R1: load-multiple in flight, then reset clears its record
      @(posedge clk); #1;
      ex_r = mk(0, 0, 0, 0, 1, 16'h0020, 0, 0, 0, 3'b000);
      drive();
      @(posedge clk); #1;
      rst_n = 1'b0;
      ex_r = bub();
      id_r = mk(1, 6, 1, 0, 0, 16'h0, 5, 0, 0, 3'b001);
      drive();
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 after reset");

      id_r = bub(); ex_r = bub(); mem_r = bub(); wb_r = bub();
      step("R1 idle");
      step("R1 idle");

      // single-producer sweep over all source/destination pairs
      for (int k = 0; k < 4; k++)
         for (int s = 0; s < 16; s++)
            for (int d = 0; d < 16; d++) begin
               logic [2:0] u;
               u = 3'b001 << (s % 3);
               id_r = mk(1, 0, 1, 0, 0, 16'h0, s, s, s, u);
               ex_r = bub(); mem_r = bub(); wb_r = bub();
               case (k)
                  0: ex_r  = mk(0, d, 1, 0, 0, 16'h0, 0, 0, 0, 3'b000);
                  1: ex_r  = mk(0, d, 1, 1, 0, 16'h0, 0, 0, 0, 3'b000);
                  2: mem_r = mk(0, d, 1, 0, 0, 16'h0, 0, 0, 0, 3'b000);
                  default: wb_r = mk(0, d, 1, 0, 0, 16'h0, 0, 0, 0, 3'b000);
               endcase
               case (k)
                  0: step("R2 R7 sweep");
                  1: step("R8 R7 sweep");
                  2: step("R3 R7 sweep");
                  default: step("R4 R7 sweep");
               endcase
            end

      // priority and write-enable sweep, all stages naming the same register
      for (int uu = 0; uu < 2; uu++)
         for (int s = 0; s < 16; s++)
            for (int m = 0; m < 8; m++) begin
               id_r  = mk(1, 0, 1, 0, 0, 16'h0, s, 0, s, uu ? 3'b101 : 3'b000);
               ex_r  = mk(0, s, m[0], 0, 0, 16'h0, 0, 0, 0, 3'b000);
               mem_r = mk(0, s, m[1], 0, 0, 16'h0, 0, 0, 0, 3'b000);
               wb_r  = mk(0, s, m[2], 0, 0, 16'h0, 0, 0, 0, 3'b000);
               step("R5 R6 priority");
            end

      // R9: six independent instructions
      for (int i = 0; i < 6; i++) prog[i] = mk(i, i + 1, 1, 0, 0, 16'h0, 8, 9, 10, 3'b011);
      run_seq(6, 0, "R9 no hazard");

      // R3: ADD r1; SUB r4,r5,r1; AND r6,r1,r7
      prog[0] = mk(0, 1, 1, 0, 0, 16'h0, 2, 3, 0, 3'b011);
      prog[1] = mk(1, 4, 1, 0, 0, 16'h0, 5, 1, 0, 3'b011);
      prog[2] = mk(2, 6, 1, 0, 0, 16'h0, 1, 7, 0, 3'b011);
      run_seq(3, 0, "R3 chain");

      // R8: LDR r1; SUB r4,r1,r5; AND r6,r1,r7; ORR r8,r1,r9; two fillers
      prog[0] = mk(0, 1, 1, 1, 0, 16'h0, 2, 0, 0, 3'b001);
      prog[1] = mk(1, 4, 1, 0, 0, 16'h0, 1, 5, 0, 3'b011);
      prog[2] = mk(2, 6, 1, 0, 0, 16'h0, 1, 7, 0, 3'b011);
      prog[3] = mk(3, 8, 1, 0, 0, 16'h0, 1, 9, 0, 3'b011);
      prog[4] = mk(4, 10, 1, 0, 0, 16'h0, 11, 12, 0, 3'b011);
      prog[5] = mk(5, 11, 1, 0, 0, 16'h0, 12, 13, 0, 3'b011);
      run_seq(6, 1, "R8 load use");

      // R11: LDM {r1,r2,r5}; ADD reading r5 and r2
      prog[0] = mk(0, 0, 0, 0, 1, 16'h0026, 13, 0, 0, 3'b001);
      prog[1] = mk(1, 6, 1, 0, 0, 16'h0, 5, 2, 0, 3'b011);
      prog[2] = mk(2, 7, 1, 0, 0, 16'h0, 8, 9, 0, 3'b011);
      prog[3] = mk(3, 8, 1, 0, 0, 16'h0, 9, 10, 0, 3'b011);
      run_seq(4, 2, "R11 ldm top");

      // R10: LDM {r1,r2,r5}; SUB reading r2 only
      prog[1] = mk(1, 6, 1, 0, 0, 16'h0, 2, 3, 0, 3'b011);
      run_seq(4, 1, "R10 ldm lower");

      // R7: write to PC followed by read of PC and use with load to PC
      prog[0] = mk(0, 15, 1, 1, 0, 16'h0, 1, 0, 0, 3'b001);
      prog[1] = mk(1, 2, 1, 0, 0, 16'h0, 15, 15, 15, 3'b111);
      prog[2] = mk(2, 3, 1, 0, 0, 16'h0, 15, 4, 0, 3'b011);
      run_seq(3, 0, "R7 pc");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule